// File: doc/BRIEF.md
# Multiplexed Two-Bank Segment Display Scanner

This block scans a matrix of seven-segment displays in turn. There are sixteen common (digit-select) lines. They are driven through an external serial-in shift register, and the block controls that register with three pins: a shift clock, serial data and an active-low clear. On every step the block empties the register and shifts in a single one. It then shifts in as many zeros as the current position index, so the one lands on the select line for that position.

Two segment buses are driven in parallel. Bank A serves displays 1 to 16 and bank B serves displays 17 to 32. Their bytes come from an external 32-byte segment memory through a read port: byte `pos` feeds bank A and byte `16 + pos` feeds bank B. The read port has no back-pressure. The memory must return `rd_data` exactly one cycle after a cycle with `rd_en` high, and the block never stalls a read.

Both buses stay blank from the start of a step until the whole select pattern is in place. This prevents ghosting on neighbouring digits. The time spent on each digit comes from the `dwell_ticks` input, which is sampled when a step starts.

Top module: `mux_scan_top`

## Requirements
- R1: While `rst_n` is low, `sr_clr_n`, `sr_clk`, `rd_en`, `seg_a` and `seg_b` are all 0. The first step after reset release serves position 0.
- R2: Every step opens with `sr_clr_n` held low for PHASE_CYC cycles. Both segment buses are 0 for as long as `sr_clr_n` is low.
- R3: After the clear, a step at position p gives exactly p+1 rising edges on `sr_clk`. `sr_dat` is 1 for the first edge and 0 for the rest, so a shift register that takes bit 0 in on each rise holds exactly one 1, at bit p.
- R4: Each high phase and each low phase of `sr_clk` lasts at least PHASE_CYC cycles. `sr_dat` does not change while `sr_clk` is high. `sr_clk` is never high while `sr_clr_n` is low.
- R5: Both segment buses stay 0 until all p+1 shift pulses of the step are complete. They then change from blank to their new bytes in the same cycle and hold those bytes until the next step's clear.
- R6: A step at position p shows memory byte p on `seg_a` and memory byte 16+p on `seg_b`. The bytes are read by raising `rd_en` with `rd_addr`, and the data is taken one cycle later.
- R7: Positions advance by one per step, from 0 up to 15, and then wrap back to 0.
- R8: The falling edges of `sr_clr_n` on consecutive steps are `dwell_ticks` cycles apart, using the value sampled when the earlier step started. If that value is shorter than the time needed to shift and fetch, the step lasts until its segments have been driven. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwell_ticks | input | DWELL_W | Step length in clock cycles, sampled at step start |
| rd_data | input | SEG_W | Segment byte returned one cycle after a read |
| rd_en | output | 1 | Segment memory read strobe |
| rd_addr | output | ADDR_W | Segment memory byte address |
| sr_clk | output | 1 | Shift register clock |
| sr_dat | output | 1 | Shift register serial data |
| sr_clr_n | output | 1 | Shift register clear, active low |
| seg_a | output | SEG_W | Segment bus for displays 1 to 16 |
| seg_b | output | SEG_W | Segment bus for displays 17 to 32 |

## Verification
A position counter that is off by one shows up before the step ends. The external register model then holds its one at the wrong bit, the pulse count is wrong, and the wrong memory bytes appear on the buses. A shifter phase counter that runs short shows up on the very next `sr_clk` edge as a phase narrower than PHASE_CYC. A fault in blanking or in the order of segment updates shows up in the first cycle where a bus is non-zero while pulses are still owed or while the clear is low. A timer fault shows up as a wrong spacing between two consecutive clear edges.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SEQ_INIT,
    SEQ_SHIFT,
    SEQ_FETCH,
    SEQ_SHOW
  } seq_st_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_CLR,
    SH_LOW,
    SH_HIGH
  } sh_st_t;

  typedef enum logic [1:0] {
    FT_IDLE,
    FT_RDA,
    FT_RDB,
    FT_CAP
  } ft_st_t;

endpackage

// File: rtl/scan_dwell_timer.sv
module scan_dwell_timer #(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DWELL_W-1:0] reload,
  output logic               expired
);

  logic [DWELL_W-1:0] cnt_q;

  // Loading D makes expiry visible D-1 cycles later, so the next load
  // (driven by expiry) lands exactly D cycles after this one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (reload == '0) ? '0 : reload - DWELL_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DWELL_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/scan_select_shifter.sv
module scan_select_shifter
  import scan_pkg::*;
#(
  parameter int NB_W      = 5,
  parameter int PHASE_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NB_W-1:0] nbits,
  output logic            sr_clk_o,
  output logic            sr_dat_o,
  output logic            sr_clr_n_o,
  output logic            done_o
);

  localparam int PH_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(PHASE_CYC - 1);

  sh_st_t          st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [NB_W-1:0] left_q, left_d;
  logic            first_q, first_d;
  logic            done_d;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    left_d  = left_q;
    first_d = first_q;
    done_d  = 1'b0;
    if (start) begin
      st_d = SH_CLR;
      ph_d = PH_MAX;
    end else begin
      case (st_q)
        SH_CLR: begin
          if (ph_q == '0) begin
            st_d    = SH_LOW;
            ph_d    = PH_MAX;
            left_d  = nbits;
            first_d = 1'b1;
          end else begin
            ph_d = ph_q - PH_W'(1);
          end
        end
        SH_LOW: begin
          if (ph_q == '0) begin
            st_d = SH_HIGH;
            ph_d = PH_MAX;
          end else begin
            ph_d = ph_q - PH_W'(1);
          end
        end
        SH_HIGH: begin
          if (ph_q == '0) begin
            if (left_q <= NB_W'(1)) begin
              st_d   = SH_IDLE;
              done_d = 1'b1;
            end else begin
              st_d    = SH_LOW;
              ph_d    = PH_MAX;
              left_d  = left_q - NB_W'(1);
              first_d = 1'b0;
            end
          end else begin
            ph_d = ph_q - PH_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SH_IDLE;
      ph_q       <= '0;
      left_q     <= '0;
      first_q    <= 1'b0;
      sr_clk_o   <= 1'b0;
      sr_dat_o   <= 1'b0;
      sr_clr_n_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      left_q     <= left_d;
      first_q    <= first_d;
      // Pins are registered from the next state so they never glitch.
      sr_clr_n_o <= (st_d != SH_CLR);
      sr_clk_o   <= (st_d == SH_HIGH);
      sr_dat_o   <= ((st_d == SH_LOW) || (st_d == SH_HIGH)) && first_d;
      done_o     <= done_d;
    end
  end

endmodule

// File: rtl/scan_seg_fetch.sv
module scan_seg_fetch
  import scan_pkg::*;
#(
  parameter int NUM_POS = 16,
  parameter int SEG_W   = 8,
  parameter int POS_W   = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic              go,
  input  logic [POS_W-1:0]  pos,
  input  logic [SEG_W-1:0]  rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [SEG_W-1:0]  seg_a,
  output logic [SEG_W-1:0]  seg_b,
  output logic              done
);

  ft_st_t           st_q;
  logic [SEG_W-1:0] stage_a_q;
  logic [ADDR_W-1:0] base_addr;

  assign base_addr = ADDR_W'(pos);

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (st_q)
      FT_RDA: begin
        rd_en   = 1'b1;
        rd_addr = base_addr;
      end
      FT_RDB: begin
        rd_en   = 1'b1;
        rd_addr = base_addr + ADDR_W'(NUM_POS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FT_IDLE;
      stage_a_q <= '0;
      seg_a     <= '0;
      seg_b     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (blank) begin
        seg_a <= '0;
        seg_b <= '0;
      end
      case (st_q)
        FT_IDLE: if (go) st_q <= FT_RDA;
        FT_RDA:  st_q <= FT_RDB;
        FT_RDB: begin
          stage_a_q <= rd_data;
          st_q      <= FT_CAP;
        end
        FT_CAP: begin
          // Both banks switch on together.
          seg_a <= stage_a_q;
          seg_b <= rd_data;
          done  <= 1'b1;
          st_q  <= FT_IDLE;
        end
        default: st_q <= FT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mux_scan_top.sv
module mux_scan_top
  import scan_pkg::*;
#(
  parameter int NUM_POS   = 16,
  parameter int SEG_W     = 8,
  parameter int PHASE_CYC = 2,
  parameter int DWELL_W   = 16,
  localparam int POS_W    = $clog2(NUM_POS),
  localparam int ADDR_W   = $clog2(2 * NUM_POS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DWELL_W-1:0] dwell_ticks,
  input  logic [SEG_W-1:0]   rd_data,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               sr_clk,
  output logic               sr_dat,
  output logic               sr_clr_n,
  output logic [SEG_W-1:0]   seg_a,
  output logic [SEG_W-1:0]   seg_b
);

  localparam int NB_W = POS_W + 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

  seq_st_t          seq_q;
  logic [POS_W-1:0] pos_q;
  logic             step_go;
  logic             tmr_expired;
  logic             sh_done;
  logic             ft_go;
  logic             ft_done;
  logic [NB_W-1:0]  nbits;

  assign step_go = (seq_q == SEQ_INIT) || ((seq_q == SEQ_SHOW) && tmr_expired);
  assign ft_go   = (seq_q == SEQ_SHIFT) && sh_done;
  assign nbits   = NB_W'(pos_q) + NB_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_INIT;
      pos_q <= '0;
    end else begin
      case (seq_q)
        SEQ_INIT:  seq_q <= SEQ_SHIFT;
        SEQ_SHIFT: if (sh_done) seq_q <= SEQ_FETCH;
        SEQ_FETCH: if (ft_done) seq_q <= SEQ_SHOW;
        SEQ_SHOW: begin
          if (tmr_expired) begin
            seq_q <= SEQ_SHIFT;
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
          end
        end
        default: seq_q <= SEQ_INIT;
      endcase
    end
  end

  scan_dwell_timer #(
    .DWELL_W(DWELL_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (step_go),
    .reload (dwell_ticks),
    .expired(tmr_expired)
  );

  scan_select_shifter #(
    .NB_W     (NB_W),
    .PHASE_CYC(PHASE_CYC)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (step_go),
    .nbits     (nbits),
    .sr_clk_o  (sr_clk),
    .sr_dat_o  (sr_dat),
    .sr_clr_n_o(sr_clr_n),
    .done_o    (sh_done)
  );

  scan_seg_fetch #(
    .NUM_POS(NUM_POS),
    .SEG_W  (SEG_W),
    .POS_W  (POS_W),
    .ADDR_W (ADDR_W)
  ) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .blank  (step_go),
    .go     (ft_go),
    .pos    (pos_q),
    .rd_data(rd_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .seg_a  (seg_a),
    .seg_b  (seg_b),
    .done   (ft_done)
  );

endmodule

// File: rtl/mux_scan_chk.sv
module mux_scan_chk #(
  parameter int SEG_W = 8,
  parameter int POS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sr_clk,
  input logic             sr_dat,
  input logic             sr_clr_n,
  input logic [SEG_W-1:0] seg_a,
  input logic [SEG_W-1:0] seg_b,
  input logic [POS_W-1:0] pos_q
);

  assert_blank_in_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_clr_n |-> (seg_a == '0 && seg_b == '0));

  assert_blank_while_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk |-> (seg_a == '0 && seg_b == '0));

  assert_no_clk_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_clr_n |-> !sr_clk);

  assert_dat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_clk && $past(sr_clk)) |-> $stable(sr_dat));

  assert_seg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(seg_a) != '0) && (seg_a != '0)) |-> (seg_a == $past(seg_a)));

  assert_pos_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |-> ((pos_q == '0) || (pos_q == $past(pos_q) + POS_W'(1))));

endmodule

bind mux_scan_top mux_scan_chk #(
  .SEG_W(SEG_W),
  .POS_W(POS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sr_clk  (sr_clk),
  .sr_dat  (sr_dat),
  .sr_clr_n(sr_clr_n),
  .seg_a   (seg_a),
  .seg_b   (seg_b),
  .pos_q   (pos_q)
);

// File: tb/mux_scan_top_bench.sv
`timescale 1ns/1ps
module mux_scan_top_bench;

  localparam int NP = 16;
  localparam int SW = 8;
  localparam int PH = 2;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int EXACT_MIN = 80;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] dwell;
  logic [SW-1:0] rd_data = '0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          sr_clk, sr_dat, sr_clr_n;
  logic [SW-1:0] seg_a, seg_b;

  always #2.5 clk = ~clk;

  mux_scan_top u_mux_scan_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .dwell_ticks(dwell),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .sr_clk     (sr_clk),
    .sr_dat     (sr_dat),
    .sr_clr_n   (sr_clr_n),
    .seg_a      (seg_a),
    .seg_b      (seg_b)
  );

  function automatic logic [SW-1:0] mem_val(int i);
    return SW'((i * 29 + 17) % 255 + 1);
  endfunction

  logic [SW-1:0] mem [0:2*NP-1];
  initial for (int i = 0; i < 2 * NP; i++) mem[i] = mem_val(i);

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int checks = 0, errors = 0, steps = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor state: a model of the external shift register and step counters.
  int exp_pos, pulses, hi_run, lo_run, since_fall, d_loaded;
  bit first_step, after_reset, seg_seen, prev_clk, prev_clr;
  logic [NP-1:0] sh_model;
  logic [SW-1:0] cap_a, cap_b;

  task automatic end_step();
    string rq;
    rq = (exp_pos == 0 && !first_step) ? "R7" : "R3";
    if (after_reset) rq = "R1";
    chk(sh_model == (NP'(1) << exp_pos), rq, "select pattern", sh_model, NP'(1) << exp_pos);
    chk(pulses == exp_pos + 1, "R3", "shift pulse count", pulses, exp_pos + 1);
    chk(seg_seen, "R5", "segments driven in step", seg_seen, 1);
    chk(cap_a == mem_val(exp_pos), "R6", "bank A byte", cap_a, mem_val(exp_pos));
    chk(cap_b == mem_val(NP + exp_pos), "R6", "bank B byte", cap_b, mem_val(NP + exp_pos));
    if (!first_step) begin
      if (d_loaded >= EXACT_MIN)
        chk(since_fall == d_loaded, "R8", "step period", since_fall, d_loaded);
      else
        chk(since_fall >= d_loaded && since_fall < EXACT_MIN, "R8", "stretched period",
            since_fall, d_loaded);
    end
    exp_pos     = (exp_pos + 1) % NP;
    pulses      = 0;
    seg_seen    = 0;
    since_fall  = 0;
    first_step  = 0;
    after_reset = 0;
    d_loaded    = int'(dwell);
    steps++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_pos = 0; pulses = 0; hi_run = 0; lo_run = 0; since_fall = 0;
      first_step = 1; after_reset = 1; seg_seen = 0; prev_clk = 0; prev_clr = 0;
      sh_model = '0; cap_a = '0; cap_b = '0; d_loaded = int'(dwell);
    end else begin
      since_fall++;
      if (prev_clr && !sr_clr_n) end_step();
      if (!sr_clr_n) begin
        sh_model = '0;
        chk(seg_a == '0 && seg_b == '0, "R2", "segments during clear", {seg_a, seg_b}, 0);
      end
      if (sr_clk) begin
        if (!prev_clk) begin
          chk(lo_run >= PH, "R4", "low phase width", lo_run, PH);
          sh_model = {sh_model[NP-2:0], sr_dat};
          pulses++;
          hi_run = 0;
        end
        hi_run++;
      end else begin
        if (prev_clk) begin
          chk(hi_run >= PH, "R4", "high phase width", hi_run, PH);
          lo_run = 0;
        end
        if (sr_clr_n) lo_run++;
        else lo_run = 0;
      end
      if (seg_a != '0 || seg_b != '0) begin
        if (!seg_seen) begin
          seg_seen = 1;
          chk(seg_a != '0 && seg_b != '0, "R5", "banks switch together", {seg_a, seg_b}, 1);
          chk(pulses == exp_pos + 1 && !sr_clk, "R5", "segments only after pattern",
              pulses, exp_pos + 1);
          cap_a = seg_a;
          cap_b = seg_b;
        end else begin
          chk(seg_a == cap_a && seg_b == cap_b, "R5", "segments hold", {seg_a, seg_b},
              {cap_a, cap_b});
        end
      end
      prev_clk = sr_clk;
      prev_clr = sr_clr_n;
    end
  end

  task automatic reset_checks();
    chk(sr_clr_n == 1'b0, "R1", "clear held in reset", sr_clr_n, 0);
    chk(sr_clk == 1'b0, "R1", "shift clock in reset", sr_clk, 0);
    chk(rd_en == 1'b0, "R1", "no read in reset", rd_en, 0);
    chk(seg_a == '0 && seg_b == '0, "R1", "segments in reset", {seg_a, seg_b}, 0);
  endtask

  initial begin
    int s0;
    rst_n = 1'b0;
    dwell = DW'(100);
    repeat (4) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    // Two full rounds at a long dwell: exact periods and wrap.
    wait (steps == 2 * NP);
    @(posedge clk); #1 dwell = DW'(137);
    wait (steps == 2 * NP + 18);
    // Dwell shorter than the build time: steps stretch but stay complete.
    @(posedge clk); #1 dwell = DW'(8);
    wait (steps == 2 * NP + 38);
    // Reset in the middle of a round.
    repeat (23) @(negedge clk);
    rst_n = 1'b0;
    dwell = DW'(0);
    repeat (3) @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    s0 = steps;
    // A zero dwell acts as a short one; steps still complete.
    wait (steps == s0 + 20);
    @(posedge clk); #1 dwell = DW'(100);
    wait (steps == s0 + 40);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d steps", steps, 0);
    finish_run();
  end

endmodule